// File: doc/BRIEF.md
# Interlaced Field Detector with Edge Compensation

This block runs in the pixel clock domain of an interlaced video input. It decides whether each frame period is field A or field B, and it issues a one-clock vertical reference strobe that the memory write control uses as its start point. The decision uses a horizontal position counter that restarts on every horizontal sync pulse. The counter is sampled at the chosen vertical sync edge. If the edge lands near the middle of a line, the field is B. If it lands anywhere else, the field is A.

Three static configuration pins shape the behaviour:

- **Edge select** picks the vertical sync edge: falling (trailing, the default) or rising (leading). The leading edge is for sources whose trailing edge has no defined phase against horizontal sync.
- **Field invert** flips the reported field.
- **Compensation** only acts when the leading edge is selected. It swaps the field and holds back the reference strobe of every field that ends up as B until the next horizontal sync pulse, which is one line later.

A status pin reports whether valid data starts one line late.

All pins are plain level or pulse signals. No data stream passes through the block, so it has no valid/ready handshake and cannot be back-pressured. The configuration pins are expected to change only while no vertical edge is near.

Top module: `ifd_field_det`

## Requirements
- R1: While reset is active and in the first cycle after it, `field_b_o` and `vref_o` are 0.
- R2: With `cfg_lead_edge_i`=0, the reference is the falling edge of registered vsync (sync pulses are active high). The horizontal position is the number of clocks since the registered hsync rising edge; it is 0 in the cycle that follows that edge. A position within LINE_LEN/2±TOL gives field B (`field_b_o`=1). Any other position gives field A (`field_b_o`=0).
- R3: With `cfg_lead_edge_i`=1, the rising edge of registered vsync is the reference. It is classified by the same position rule.
- R4: With `cfg_field_inv_i`=1, the reported field is the inverse of the classified field.
- R5: `field_b_o` takes its new value one clock after a reference edge and holds at all other times.
- R6: When the reference strobe is not delayed, `vref_o` is a single-clock pulse in the same cycle that `field_b_o` updates.
- R7: With both `cfg_lead_edge_i` and `cfg_comp_en_i` at 1, the classified field is swapped. A field that ends up as B gets no immediate strobe. Its `vref_o` pulse follows the first registered hsync rising edge after the reference edge.
- R8: With `cfg_lead_edge_i`=0, `cfg_comp_en_i` has no effect on `field_b_o` or `vref_o`.
- R9: `start_late_o` is 1 (data starts at line n+1) only when the leading edge is selected and compensation is off. Otherwise it is 0 (line n).
- R10: Sometimes a delayed strobe is released in the same cycle as a new reference edge that is itself delayed. In that case one `vref_o` pulse is issued and the new delay stays pending for the next hsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| cfg_lead_edge_i | input | 1 | 1: leading (rising) vsync edge is the reference |
| cfg_field_inv_i | input | 1 | 1: invert the reported field |
| cfg_comp_en_i | input | 1 | 1: swap field and delay field-B strobe (leading edge only) |
| field_b_o | output | 1 | Current field, 1 = B, 0 = A |
| vref_o | output | 1 | One-clock vertical reference strobe |
| start_late_o | output | 1 | 1 = valid data starts one line late |

## Verification
Two functions can fall in the same clock. One is the release of a held field-B strobe by a horizontal sync pulse. The other is a fresh reference edge that the block must classify and possibly hold again. The bench provokes this with a short vsync pulse whose second rising edge lands exactly on the hsync rising sample that releases the previous held strobe. A cycle-accurate behavioural model in the bench checks that the cycle gets exactly one strobe and that a second strobe follows on the next line.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  typedef enum logic {
    FIELD_A = 1'b0,
    FIELD_B = 1'b1
  } field_e;

  typedef struct packed {
    logic lead;
    logic inv;
    logic comp;
  } ifd_cfg_t;
endpackage

// File: rtl/ifd_edge_det.sv
module ifd_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  logic cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= sig_i;
      prev_q <= cur_q;
    end
  end

  assign edge_o = rise_sel_i ? (cur_q & ~prev_q) : (~cur_q & prev_q);
endmodule

// File: rtl/ifd_hpos_ctr.sv
module ifd_hpos_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)              pos_o <= '0;
    else if (clr_i)          pos_o <= '0;
    else if (pos_o != POS_MAX) pos_o <= pos_o + 1'b1;
  end

  // R2
  pos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pos_o == '0));
endmodule

// File: rtl/ifd_classify.sv
module ifd_classify #(
  parameter int LINE_LEN = 1716,
  parameter int TOL      = 64,
  parameter int CNT_W    = 12
) (
  input  logic [CNT_W-1:0] pos_i,
  output logic             mid_o
);
  localparam int HALF = LINE_LEN / 2;
  localparam int LO   = (HALF > TOL) ? HALF - TOL : 0;
  localparam int HI   = HALF + TOL;
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI);

  generate
    if (LO == 0) begin : g_open_low
      assign mid_o = (pos_i <= HI_C);
    end else begin : g_window
      assign mid_o = (pos_i >= LO_C) && (pos_i <= HI_C);
    end
  endgenerate
endmodule

// File: rtl/ifd_vref_sched.sv
module ifd_vref_sched (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic field_i,
  input  logic delay_i,
  input  logic hs_ev_i,
  output logic field_o,
  output logic vref_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_o <= 1'b0;
      vref_o  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (ev_i) field_o <= field_i;
      vref_o <= (ev_i & ~delay_i) | (hs_ev_i & pend_q);
      if (ev_i && delay_i) pend_q <= 1'b1;
      else if (hs_ev_i)    pend_q <= 1'b0;
    end
  end

  // R5
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_i |=> $stable(field_o));

  // R6
  vref_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && !delay_i) |=> vref_o);

  // R7
  vref_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ev_i && pend_q) |=> vref_o);

  // R10
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && delay_i) |=> pend_q);

  // R6
  vref_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vref_o) |-> $past(ev_i || hs_ev_i));
endmodule

// File: rtl/ifd_field_det.sv
module ifd_field_det #(
  parameter int LINE_LEN = 1716,
  parameter int TOL      = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic cfg_lead_edge_i,
  input  logic cfg_field_inv_i,
  input  logic cfg_comp_en_i,
  output logic field_b_o,
  output logic vref_o,
  output logic start_late_o
);
  import ifd_pkg::*;

  localparam int CNT_W = $clog2(LINE_LEN) + 1;

  ifd_cfg_t         cfg;
  logic             hs_ev, v_ev, mid, swap, delay;
  logic [CNT_W-1:0] hpos;
  field_e           raw_fld, fin_fld;

  assign cfg = '{lead: cfg_lead_edge_i, inv: cfg_field_inv_i, comp: cfg_comp_en_i};

  ifd_edge_det u_hs_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(hsync_i), .rise_sel_i(1'b1), .edge_o(hs_ev)
  );

  ifd_edge_det u_vs_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(vsync_i), .rise_sel_i(cfg.lead), .edge_o(v_ev)
  );

  ifd_hpos_ctr #(.CNT_W(CNT_W)) u_hpos (
    .clk(clk), .rst_n(rst_n), .clr_i(hs_ev), .pos_o(hpos)
  );

  ifd_classify #(.LINE_LEN(LINE_LEN), .TOL(TOL), .CNT_W(CNT_W)) u_cls (
    .pos_i(hpos), .mid_o(mid)
  );

  assign swap    = cfg.lead & cfg.comp;
  assign raw_fld = mid ? FIELD_B : FIELD_A;
  assign fin_fld = field_e'(raw_fld ^ cfg.inv ^ swap);
  assign delay   = swap & (fin_fld == FIELD_B);

  ifd_vref_sched u_sched (
    .clk(clk), .rst_n(rst_n), .ev_i(v_ev), .field_i(fin_fld), .delay_i(delay),
    .hs_ev_i(hs_ev), .field_o(field_b_o), .vref_o(vref_o)
  );

  assign start_late_o = cfg.lead & ~cfg.comp;

  // R9
  late_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_late_o |-> (cfg_lead_edge_i && !cfg_comp_en_i));
endmodule

// File: tb/ifd_field_det_bench.sv
`timescale 1ns/1ps
module ifd_field_det_bench;
  localparam int LL   = 64;
  localparam int TOL  = 8;
  localparam int PMAX = 127;
  localparam int NL   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, vs = 1'b0, lead = 1'b0, inv = 1'b0, comp = 1'b0;
  logic fld, vref, late;

  int total = 0, bad = 0;
  bit done = 0;

  int pos = 0;
  bit hs_p = 0, vs_p = 0, pend = 0;
  bit e_fld = 0, e_vref = 0;
  string fld_tag = "R2 R5";
  string vref_tag = "R6";

  always #2 clk = ~clk;

  ifd_field_det #(.LINE_LEN(LL), .TOL(TOL)) u_ifd_field_det (
    .clk(clk), .rst_n(rst_n), .hsync_i(hs), .vsync_i(vs),
    .cfg_lead_edge_i(lead), .cfg_field_inv_i(inv), .cfg_comp_en_i(comp),
    .field_b_o(fld), .vref_o(vref), .start_late_o(late)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic tick();
    bit hs_r, v_e, raw, sw, f, n_vref;
    check(fld == e_fld, fld_tag, fld, e_fld);
    check(vref == e_vref, vref_tag, vref, e_vref);
    check(late == (lead && !comp), "R9", late, lead && !comp);
    hs_r = hs && !hs_p;
    v_e  = lead ? (vs && !vs_p) : (!vs && vs_p);
    n_vref = 0;
    if (hs_r && pend) begin n_vref = 1; pend = 0; end
    if (v_e) begin
      raw = (pos >= LL/2 - TOL) && (pos <= LL/2 + TOL);
      sw  = lead && comp;
      f   = raw ^ inv ^ sw;
      e_fld = f;
      if (sw && f) pend = 1;
      else n_vref = 1;
    end
    e_vref = n_vref;
    if (hs_r) pos = 0;
    else if (pos < PMAX) pos++;
    hs_p = hs;
    vs_p = vs;
  endtask

  task automatic frame(input int a0, input int a1, input int a2, input int a3);
    for (int c = 0; c < NL*LL; c++) begin
      @(negedge clk);
      tick();
      hs = (c % LL) < 4;
      vs = (c >= a0 && c < a1) || (c >= a2 && c < a3);
    end
  endtask

  task automatic scenario(input bit l, input bit i, input bit cm,
                          input string ft, input string vt);
    @(negedge clk);
    tick();
    lead = l; inv = i; comp = cm;
    fld_tag = ft; vref_tag = vt;
    frame(130, 258, 0, 0);
    frame(161, 289, 0, 0);
    frame(130, 258, 0, 0);
    frame(161, 289, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(fld == 1'b0, "R1", fld, 0);
    check(vref == 1'b0, "R1", vref, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fld == 1'b0 && vref == 1'b0, "R1", {fld, vref}, 0);
    tick();
    scenario(0, 0, 0, "R2 R5", "R6");
    scenario(0, 1, 0, "R4", "R6");
    scenario(1, 0, 0, "R3", "R6");
    scenario(1, 0, 1, "R7", "R7");
    scenario(0, 0, 1, "R8", "R8");
    scenario(1, 1, 1, "R7 R4", "R7");
    fld_tag = "R10"; vref_tag = "R10";
    lead = 1; inv = 0; comp = 1;
    frame(130, 148, 192, 222);
    frame(130, 148, 192, 222);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule